// File: doc/BRIEF.md
# Broadcast Control Frame Recipient Filter

Several nodes listen on one shared control channel, and every node sees every frame the scheduler sends. This block sits at the receive side of one node. Each frame arrives on a parallel bus as an 8-bit recipient field plus a 16-bit payload, marked by a one-cycle valid pulse. The block decides whether the frame is meant for this node. If it is, the block registers the payload and raises a one-cycle accept strobe for the local test logic. If it is not, the frame leaves no trace.

The recipient field has two forms, chosen by its top bit. When bit 7 is clear, bits 6:0 are a node address, and the frame matches if they equal the node's own address, which is fixed by a parameter. When bit 7 is set, bits 6:0 are a group number, and the frame matches if they equal the node's group register. Software loads that register through a small write port. The group value 7'h7F means the node belongs to no group. A multicast frame can therefore start several cores in the same cycle.

Top module: `bcf_filter`

## Requirements
- R1: Reset clears `acc_stb` and `acc_data` to zero. It also sets the group register to the no-group value 7'h7F, so no multicast frame is accepted until a group is written.
- R2: A valid frame with recipient bit 7 = 0 and bits 6:0 equal to `NODE_ID` raises `acc_stb` for exactly the next cycle, with `acc_data` equal to that frame's payload.
- R3: A valid frame that does not match raises no strobe, and `acc_data` keeps its previous value.
- R4: A valid frame with bit 7 = 1 and bits 6:0 equal to the group register is accepted, with the same timing and payload as R2, provided the group is not 7'h7F.
- R5: A frame with bit 7 = 1 is never matched on the node address, even when bits 6:0 equal `NODE_ID`.
- R6: While the group register holds 7'h7F, every multicast frame is rejected, including one addressed to group 7'h7F.
- R7: `grp_wr` loads `grp_wdata` into the group register at the clock edge. A frame presented in the same cycle as the write is judged against the old group value. Frames in later cycles use the new value.
- R8: Frames on consecutive cycles are each judged on their own. A run of accepted frames gives one strobe cycle per frame, each with its own payload.
- R9: When `frm_valid` is low, the recipient and payload inputs have no effect, even if they would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle qualifier for the frame on the bus |
| frm_id | input | 8 | Recipient field: bit 7 is the multicast flag, bits 6:0 are the address or group |
| frm_data | input | 16 | Control payload |
| grp_wr | input | 1 | Group register write enable |
| grp_wdata | input | 7 | New group number (7'h7F means no group) |
| acc_stb | output | 1 | One-cycle strobe, one clock after an accepted frame |
| acc_data | output | 16 | Payload of the most recent accepted frame |

## Verification
The bench targets four cases:
- A multicast frame whose low bits equal the node address. A filter that ignores the flag would accept it.
- A frame addressed to group 7'h7F while the node has no group. A filter without the no-group guard would accept it.
- A group write in the same cycle as a frame for the new group. A design that forwards the written value would accept that frame one cycle early.
- Back-to-back accepted frames, followed by rejected frames, valid-low cycles and a long pseudo-random stream. These catch a stretched strobe, a lost frame, or a payload register that moves on a rejected frame.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
    localparam int ID_W  = 8;
    localparam int PAY_W = 16;
    localparam int TAG_W = ID_W - 1;
    localparam logic [TAG_W-1:0] NO_GROUP = {TAG_W{1'b1}};

    typedef struct packed {
        logic             mc;
        logic [TAG_W-1:0] tag;
    } rcpt_t;

    typedef struct packed {
        logic             vld;
        rcpt_t            rcpt;
        logic [PAY_W-1:0] pay;
    } frame_t;

    function automatic logic node_hit(rcpt_t r, logic [TAG_W-1:0] node);
        return !r.mc && (r.tag == node);
    endfunction

    function automatic logic group_hit(rcpt_t r, logic [TAG_W-1:0] grp);
        return r.mc && (grp != NO_GROUP) && (r.tag == grp);
    endfunction
endpackage

// File: rtl/bcf_group_reg.sv
module bcf_group_reg
    import bcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [TAG_W-1:0] wdata,
    output logic [TAG_W-1:0] grp
);
    always_ff @(posedge clk) begin
        if (rst)
            grp <= NO_GROUP;
        else if (wr)
            grp <= wdata;
    end
endmodule

// File: rtl/bcf_matcher.sv
module bcf_matcher
    import bcf_pkg::*;
#(
    parameter logic [TAG_W-1:0] NODE_ID = 7'h15
) (
    input  frame_t           frm,
    input  logic [TAG_W-1:0] grp,
    output logic             hit
);
    logic uni, multi;
    always_comb begin
        uni   = node_hit(frm.rcpt, NODE_ID);
        multi = group_hit(frm.rcpt, grp);
        hit   = frm.vld && (uni || multi);
    end
endmodule

// File: rtl/bcf_out_reg.sv
module bcf_out_reg
    import bcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [PAY_W-1:0] pay,
    output logic             stb,
    output logic [PAY_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stb  <= 1'b0;
            data <= '0;
        end else begin
            stb <= take;
            if (take)
                data <= pay;
        end
    end
endmodule

// File: rtl/bcf_filter.sv
module bcf_filter
    import bcf_pkg::*;
#(
    parameter logic [TAG_W-1:0] NODE_ID = 7'h15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_valid,
    input  logic [ID_W-1:0]  frm_id,
    input  logic [PAY_W-1:0] frm_data,
    input  logic             grp_wr,
    input  logic [TAG_W-1:0] grp_wdata,
    output logic             acc_stb,
    output logic [PAY_W-1:0] acc_data
);
    frame_t           frm;
    logic [TAG_W-1:0] grp_q;
    logic             hit;

    always_comb begin
        frm.vld  = frm_valid;
        frm.rcpt = rcpt_t'(frm_id);
        frm.pay  = frm_data;
    end

    bcf_group_reg u_grp (
        .clk   (clk),
        .rst   (rst),
        .wr    (grp_wr),
        .wdata (grp_wdata),
        .grp   (grp_q)
    );

    bcf_matcher #(.NODE_ID(NODE_ID)) u_match (
        .frm (frm),
        .grp (grp_q),
        .hit (hit)
    );

    bcf_out_reg u_out (
        .clk  (clk),
        .rst  (rst),
        .take (hit),
        .pay  (frm.pay),
        .stb  (acc_stb),
        .data (acc_data)
    );
endmodule

// File: rtl/bcf_filter_chk.sv
module bcf_filter_chk
    import bcf_pkg::*;
#(
    parameter logic [TAG_W-1:0] NODE_ID = 7'h15
) (
    input logic             clk,
    input logic             rst,
    input logic             frm_valid,
    input logic [ID_W-1:0]  frm_id,
    input logic [PAY_W-1:0] frm_data,
    input logic [TAG_W-1:0] grp_q,
    input logic             acc_stb,
    input logic [PAY_W-1:0] acc_data
);
    // R1: outputs are clear on the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!acc_stb && acc_data == '0));

    // R2: a node-address hit gives a strobe and its payload one cycle later
    p_unicast_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_id[ID_W-1] && frm_id[TAG_W-1:0] == NODE_ID)
        |=> (acc_stb && acc_data == $past(frm_data)));

    // R3: with no strobe, the payload register holds its value
    p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
        (!acc_stb && !$past(rst)) |-> $stable(acc_data));

    // R4: a group hit is accepted
    p_group_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_id[ID_W-1] && grp_q != NO_GROUP && frm_id[TAG_W-1:0] == grp_q)
        |=> (acc_stb && acc_data == $past(frm_data)));

    // R5: a multicast frame is never accepted on the node address
    p_mc_not_node_r5: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_id[ID_W-1] && frm_id[TAG_W-1:0] != grp_q) |=> !acc_stb);

    // R6: with no group, every multicast frame is dropped
    p_no_group_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_id[ID_W-1] && grp_q == NO_GROUP) |=> !acc_stb);

    // R9: valid low gives no strobe
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !acc_stb);
endmodule

bind bcf_filter bcf_filter_chk #(.NODE_ID(NODE_ID)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_valid (frm_valid),
    .frm_id    (frm_id),
    .frm_data  (frm_data),
    .grp_q     (grp_q),
    .acc_stb   (acc_stb),
    .acc_data  (acc_data)
);

// File: tb/sim_bcf_filter.sv
module sim_bcf_filter;
    localparam logic [6:0] NODE = 7'h15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [7:0]  frm_id = '0;
    logic [15:0] frm_data = '0;
    logic        grp_wr = 1'b0;
    logic [6:0]  grp_wdata = '0;
    logic        acc_stb;
    logic [15:0] acc_data;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // reference state
    logic        exp_stb = 1'b0;
    logic [15:0] exp_data = '0;
    int          exp_grp = 127;

    always #2 clk = ~clk;

    bcf_filter #(.NODE_ID(NODE)) u0 (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_data(frm_data), .grp_wr(grp_wr), .grp_wdata(grp_wdata),
        .acc_stb(acc_stb), .acc_data(acc_data)
    );

    function automatic bit model_hit(int id, int grp);
        if (id >= 128)
            return (grp != 127) && ((id - 128) == grp);
        return id == int'(NODE);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_stb  = 1'b0;
            exp_data = '0;
            exp_grp  = 127;
        end else begin
            exp_stb = frm_valid && model_hit(int'(frm_id), exp_grp);
            if (exp_stb)
                exp_data = frm_data;
            if (grp_wr)
                exp_grp = int'(grp_wdata);
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    task automatic compare();
        n_chk++;
        if (acc_stb !== exp_stb || acc_data !== exp_data) begin
            n_bad++;
            $display("FAIL %s: actual stb=%0b data=%h expected stb=%0b data=%h",
                     cur_req, acc_stb, acc_data, exp_stb, exp_data);
        end
    endtask

    // compare last cycle's result, then drive the next cycle
    task automatic step(input bit v, input logic [7:0] id, input logic [15:0] d,
                        input bit w, input logic [6:0] wd);
        @(negedge clk);
        compare();
        frm_valid = v; frm_id = id; frm_data = d;
        grp_wr = w; grp_wdata = wd;
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 16'h0000, 1'b0, 7'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        idle();
        step(1'b1, 8'hFF, 16'h1111, 1'b0, 7'h00);   // R1/R6: no group after reset
        step(1'b1, 8'h80, 16'h2222, 1'b0, 7'h00);
        idle(); idle();
        cur_req = "R2";
        step(1'b1, {1'b0, NODE}, 16'hA5A5, 1'b0, 7'h00);
        idle(); idle();
        cur_req = "R3";
        step(1'b1, 8'h16, 16'hBEEF, 1'b0, 7'h00);
        step(1'b1, 8'h14, 16'hCAFE, 1'b0, 7'h00);
        idle(); idle();
        cur_req = "R4";
        step(1'b0, 8'h00, 16'h0000, 1'b1, 7'h22);
        step(1'b1, 8'hA2, 16'h0F0F, 1'b0, 7'h00);
        idle(); idle();
        cur_req = "R5";
        step(1'b1, {1'b1, NODE}, 16'h5555, 1'b0, 7'h00);
        idle(); idle();
        cur_req = "R6";
        step(1'b0, 8'h00, 16'h0000, 1'b1, 7'h7F);
        step(1'b1, 8'hFF, 16'h7777, 1'b0, 7'h00);
        step(1'b1, 8'hA2, 16'h8888, 1'b0, 7'h00);
        idle(); idle();
        cur_req = "R7";
        step(1'b1, 8'hB0, 16'h9999, 1'b1, 7'h30);   // judged on old (no) group
        step(1'b1, 8'hB0, 16'h9A9A, 1'b0, 7'h00);   // new group applies
        idle(); idle();
        cur_req = "R8";
        step(1'b1, {1'b0, NODE}, 16'h0001, 1'b0, 7'h00);
        step(1'b1, {1'b0, NODE}, 16'h0002, 1'b0, 7'h00);
        step(1'b1, 8'hB0, 16'h0003, 1'b0, 7'h00);
        step(1'b1, 8'h16, 16'h0004, 1'b0, 7'h00);
        step(1'b1, 8'hB0, 16'h0005, 1'b0, 7'h00);
        idle(); idle();
        cur_req = "R9";
        step(1'b0, {1'b0, NODE}, 16'hDEAD, 1'b0, 7'h00);
        step(1'b0, 8'hB0, 16'hF00D, 1'b0, 7'h00);
        idle();
        cur_req = "R8";
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] rid;
            int sel;
            sel = $urandom_range(0, 5);
            case (sel)
                0: rid = {1'b0, NODE};
                1: rid = {1'b1, NODE};
                2: rid = 8'hB0;
                3: rid = 8'hFF;
                default: rid = 8'($urandom);
            endcase
            step(1'($urandom), rid, 16'($urandom), ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 3) == 0) ? 7'h7F : ($urandom_range(0, 1) ? 7'h30 : NODE));
        end
        idle(); idle();
        summary();
    end
endmodule